// File: doc/BRIEF.md
# Multi-master bus control unit

This block is the central controller of a synchronous, single-edge, multi-master on-chip bus. Masters raise request lines and the unit grants ownership to exactly one of them. It rotates round-robin among the requesters, and when nobody is asking it falls back to a designated default master. The owner then drives an address, a 5-bit opcode and a valid strobe. The unit decodes the address into a single registered slave select, and it holds that select through the data cycle until the slave answers on the shared 3-bit acknowledge.

The address of the next operation may be accepted in the same cycle in which the current one completes. Chained transfers therefore run at one data item per clock. An accepted operation that carries the lock flag keeps ownership with its master for the next operation. The unit completes an operation itself in two cases. It returns a bus-error code when the address maps to no slave or the opcode is reserved. It returns a timeout code when a slave keeps answering "wait" for too long. The timeout also releases the select and any lock, so the bus cannot deadlock.

Acknowledge codes on the 3-bit field are: 000 none, 001 wait, 010 ready, 100 bus error, 101 timeout. The address space is split into 2^RB equal regions by its top RB bits. Region s < N_SLV belongs to slave s, and any higher region is unmapped.

Top module: `obus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, gnt_o is one-hot on DEF_MST, sel_o is all zero, ack_o is 000 and tout_o is 0.
- R2: In a cycle where arbitration takes place and no request line is high, gnt_o selects DEF_MST from the next cycle on.
- R3: In a cycle where arbitration takes place and some request is high, the next gnt_o is one-hot on the first requesting master after the current owner, in ascending index order with wrap-around. The current owner itself is chosen only when it is the only requester.
- R4: Arbitration takes place in a cycle where an operation is accepted with lock_i low, or where addr_vld_i is low and no lock is held. While an address is presented but not accepted, gnt_o is unchanged.
- R5: An operation accepted with lock_i high keeps gnt_o unchanged until an operation is accepted with lock_i low (or a timeout occurs).
- R6: An operation is accepted when addr_vld_i is high and no operation is pending or the pending one completes in that cycle. A legal, mapped operation in region s drives sel_o one-hot on bit s from the next cycle until the slave returns 010 or 100.
- R7: An address presented while the current data cycle completes is accepted in that same cycle, so the select moves to the new slave with no idle cycle. An address presented during an uncompleted data cycle is stalled.
- R8: An accepted address in a region numbered N_SLV or above yields ack_o = 100 with sel_o all zero in the next cycle, for exactly one cycle.
- R9: Opcodes 0 (byte), 1 (halfword), 2 (word) and 3 to 6 (blocks of 2, 4, 8, 16 words) are legal. Opcodes 7 to 31 yield the same bus error as R8.
- R10: If a selected slave answers anything other than 010 or 100 for TO_CYC consecutive data cycles, then in the next cycle sel_o is all zero, ack_o is 101 and tout_o is 1 for one cycle, and any held lock is released.
- R11: While the slave answers 001 for fewer than TO_CYC data cycles, sel_o stays on the addressed slave, and a 010 in the TO_CYC-th data cycle completes normally without a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MST | Per-master ownership requests |
| addr_vld_i | input | 1 | Owner presents an operation this cycle |
| addr_i | input | AW | Operation address |
| opc_i | input | 5 | Operation opcode |
| lock_i | input | 1 | Chain the next operation to this one |
| slv_ack_i | input | 3 | Acknowledge driven by the selected slave |
| gnt_o | output | N_MST | One-hot ownership grant |
| sel_o | output | N_SLV | One-hot-or-zero slave select |
| ack_o | output | 3 | Acknowledge driven by the controller (000 when silent) |
| tout_o | output | 1 | Timeout pulse |

## Verification
The bench sweeps every region against every opcode. A decoder that is wrong at the mapped/unmapped boundary or at the opcode 6/7 boundary would then assert a select for a reserved operation, or raise an error for a legal one. Every owner is crossed with every request pattern. This catches an arbiter that restarts its priority at index 0, re-grants its owner too early, or forgets the default master. Overlapped and stalled addresses, locked chains and waits of exactly TO_CYC-1 and TO_CYC cycles are also driven. A wrong design would leave an idle bubble, swallow a stalled address, pass a lock to another master, time out one cycle early or late, or keep a lock held after a timeout.

// File: rtl/obus_pkg.sv
package obus_pkg;
  typedef enum logic [2:0] {
    ACK_NONE = 3'b000,
    ACK_WAIT = 3'b001,
    ACK_RDY  = 3'b010,
    ACK_ERR  = 3'b100,
    ACK_TMO  = 3'b101
  } ack_t;

  // highest legal opcode: byte, half, word, blocks of 2/4/8/16
  localparam logic [4:0] OPC_LAST = 5'd6;
endpackage

// File: rtl/obus_arb.sv
module obus_arb #(
  parameter int N_MST   = 4,
  parameter int DEF_MST = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req_i,
  input  logic             rearb_i,
  output logic [N_MST-1:0] gnt_o
);
  localparam logic [N_MST-1:0] DEF_VEC = N_MST'(1) << DEF_MST;

  logic [N_MST-1:0] gnt_q, gnt_n;
  int cur;

  always_comb begin
    cur = 0;
    for (int i = 0; i < N_MST; i++)
      if (gnt_q[i]) cur = i;
  end

  always_comb begin
    logic found;
    found = 1'b0;
    gnt_n = DEF_VEC;
    for (int k = 1; k <= N_MST; k++) begin
      int idx;
      idx = (cur + k) % N_MST;
      if (!found && req_i[idx]) begin
        gnt_n      = '0;
        gnt_n[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          gnt_q <= DEF_VEC;
    else if (rearb_i) gnt_q <= gnt_n;
  end

  assign gnt_o = gnt_q;

  // R3
  a_r3_gnt_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(gnt_q));
  // R2
  a_r2_default_grant: assert property (@(posedge clk) disable iff (rst)
    (rearb_i && req_i == '0) |=> gnt_q == DEF_VEC);
  // R3
  a_r3_grant_to_requester: assert property (@(posedge clk) disable iff (rst)
    (rearb_i && req_i != '0) |=> (gnt_q & $past(req_i)) != '0);
endmodule

// File: rtl/obus_dec.sv
module obus_dec #(
  parameter int AW    = 32,
  parameter int RB    = 2,
  parameter int N_SLV = 3
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [4:0]       opc_i,
  output logic [N_SLV-1:0] hit_o,
  output logic             err_o
);
  import obus_pkg::*;

  localparam logic [AW:0] SPAN = (AW + 1)'(1) << (AW - RB);
  localparam logic [AW:0] TOP  = SPAN * (AW + 1)'(N_SLV);

  logic [AW:0] a_ext;
  logic        legal;

  assign a_ext = {1'b0, addr_i};
  assign legal = (opc_i <= OPC_LAST);

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    localparam logic [AW:0] LO = SPAN * (AW + 1)'(s);
    localparam logic [AW:0] HI = SPAN * (AW + 1)'(s + 1);
    assign hit_o[s] = legal && (a_ext >= LO) && (a_ext < HI);
  end

  assign err_o = !legal || (a_ext >= TOP);
endmodule

// File: rtl/obus_watch.sv
module obus_watch #(
  parameter int TO_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic active_i,
  input  logic done_i,
  output logic fire_o
);
  localparam int CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TO_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = active_i && !done_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start_i || !active_i || done_i) cnt_q <= '0;
    else if (!fire_o)                           cnt_q <= cnt_q + 1'b1;
  end

  // R10
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/obus_ctrl.sv
module obus_ctrl #(
  parameter int N_MST   = 4,
  parameter int N_SLV   = 3,
  parameter int AW      = 32,
  parameter int RB      = 2,
  parameter int TO_CYC  = 16,
  parameter int DEF_MST = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req_i,
  input  logic             addr_vld_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [4:0]       opc_i,
  input  logic             lock_i,
  input  logic [2:0]       slv_ack_i,
  output logic [N_MST-1:0] gnt_o,
  output logic [N_SLV-1:0] sel_o,
  output logic [2:0]       ack_o,
  output logic             tout_o
);
  import obus_pkg::*;

  logic [N_SLV-1:0] sel_q, hit;
  logic [2:0]       ack_q;
  logic             tout_q, lock_q, dec_err;
  logic             slv_busy, ctl_busy, slv_done, done, pending, accept;
  logic             fire, rearb;

  assign slv_busy = |sel_q;
  assign ctl_busy = (ack_q != ACK_NONE);
  assign slv_done = slv_busy && (slv_ack_i == ACK_RDY || slv_ack_i == ACK_ERR);
  assign done     = ctl_busy || slv_done;
  assign pending  = slv_busy || ctl_busy;
  assign accept   = addr_vld_i && (!pending || done);
  assign rearb    = accept ? !lock_i : (!lock_q && !addr_vld_i);

  obus_dec #(.AW(AW), .RB(RB), .N_SLV(N_SLV)) u_dec (
    .addr_i(addr_i), .opc_i(opc_i), .hit_o(hit), .err_o(dec_err)
  );

  obus_watch #(.TO_CYC(TO_CYC)) u_watch (
    .clk(clk), .rst(rst), .start_i(accept), .active_i(slv_busy),
    .done_i(slv_done), .fire_o(fire)
  );

  obus_arb #(.N_MST(N_MST), .DEF_MST(DEF_MST)) u_arb (
    .clk(clk), .rst(rst), .req_i(req_i), .rearb_i(rearb), .gnt_o(gnt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ack_q  <= ACK_NONE;
      tout_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (accept) begin
      sel_q  <= dec_err ? '0 : hit;
      ack_q  <= dec_err ? ACK_ERR : ACK_NONE;
      tout_q <= 1'b0;
      lock_q <= lock_i;
    end else if (fire) begin
      sel_q  <= '0;
      ack_q  <= ACK_TMO;
      tout_q <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      if (done) sel_q <= '0;
      ack_q  <= ACK_NONE;
      tout_q <= 1'b0;
    end
  end

  assign sel_o  = sel_q;
  assign ack_o  = ack_q;
  assign tout_o = tout_q;

  // R6
  a_r6_sel_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  // R8
  a_r8_err_no_select: assert property (@(posedge clk) disable iff (rst)
    (ack_q == ACK_ERR) |-> (sel_q == '0));
  // R5
  a_r5_lock_holds_grant: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !accept) |=> $stable(gnt_o));
  // R10
  a_r10_timeout_release: assert property (@(posedge clk) disable iff (rst)
    fire |=> (tout_q && sel_q == '0 && ack_q == ACK_TMO && !lock_q));
  // R11
  a_r11_wait_keeps_select: assert property (@(posedge clk) disable iff (rst)
    (slv_busy && slv_ack_i == ACK_WAIT && !fire) |=> $stable(sel_q));
endmodule

// File: tb/sim_obus_ctrl.sv
module sim_obus_ctrl;
  localparam int NM = 3, NS = 3, AW = 8, RB = 2, TO = 4, DEF = 0;

  logic          clk = 1'b0, rst = 1'b1;
  logic [NM-1:0] req = '0;
  logic          vld = 1'b0, lock = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [4:0]    opc = '0;
  logic [2:0]    sack = 3'b000;
  logic [NM-1:0] gnt;
  logic [NS-1:0] sel;
  logic [2:0]    ack;
  logic          tout;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  obus_ctrl #(.N_MST(NM), .N_SLV(NS), .AW(AW), .RB(RB), .TO_CYC(TO),
              .DEF_MST(DEF)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .addr_vld_i(vld), .addr_i(addr),
    .opc_i(opc), .lock_i(lock), .slv_ack_i(sack), .gnt_o(gnt), .sel_o(sel),
    .ack_o(ack), .tout_o(tout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NM-1:0] rr(input int p, input logic [NM-1:0] pat);
    logic [NM-1:0] r;
    bit found;
    r = NM'(1) << DEF;
    found = 0;
    for (int k = 1; k <= NM; k++) begin
      int idx;
      idx = (p + k) % NM;
      if (!found && pat[idx]) begin
        r = NM'(1) << idx;
        found = 1;
      end
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] mk(input int region);
    return {2'(region), 6'h05};
  endfunction

  task automatic own(input int p);
    req = NM'(1) << p;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == 3'b001 && sel == 0 && ack == 0 && tout == 0, "R1 in reset",
        {gnt, sel, ack, tout}, {3'b001, 3'b000, 3'b000, 1'b0});
    rst = 1'b0;
    cyc();
    chk(gnt == 3'b001 && sel == 0 && ack == 0 && tout == 0, "R1 after reset",
        {gnt, sel, ack, tout}, {3'b001, 3'b000, 3'b000, 1'b0});

    // R6 R8 R9: every region against every opcode
    for (int rg = 0; rg < 4; rg++) begin
      for (int oc = 0; oc < 32; oc++) begin
        bit good;
        good = (rg < NS) && (oc <= 6);
        addr = mk(rg); opc = 5'(oc); vld = 1'b1;
        cyc();
        vld = 1'b0;
        if (good) begin
          chk(sel == NS'(1 << rg) && ack == 0, "R6 select",
              {sel, ack}, {3'(1 << rg), 3'b000});
          sack = 3'b010;
          cyc();
          sack = 3'b000;
          chk(sel == 0 && ack == 0, "R6 release", {sel, ack}, 0);
        end else begin
          chk(sel == 0 && ack == 3'b100, (rg >= NS) ? "R8 unmapped" : "R9 reserved opc",
              {sel, ack}, {3'b000, 3'b100});
          cyc();
          chk(ack == 0, "R8 error one cycle", ack, 0);
        end
      end
    end
    opc = 5'd2;

    // R2 R3: each owner against each request pattern
    for (int p = 0; p < NM; p++) begin
      for (int pat = 0; pat < 8; pat++) begin
        own(p);
        chk(gnt == NM'(1 << p), "R3 set owner", gnt, 1 << p);
        req = 3'(pat);
        cyc();
        chk(gnt == rr(p, 3'(pat)), (pat == 0) ? "R2 default" : "R3 round robin",
            gnt, rr(p, 3'(pat)));
      end
    end

    // R4: grant holds while presented address is stalled
    own(0);
    req = 3'b111; addr = mk(0); vld = 1'b1;
    cyc();
    chk(gnt == 3'b010, "R4 rearb on accept", gnt, 3'b010);
    sack = 3'b001;
    cyc();
    chk(gnt == 3'b010 && sel == 3'b001, "R4 stalled hold", {gnt, sel}, {3'b010, 3'b001});
    vld = 1'b0;
    cyc();
    chk(gnt == 3'b100, "R4 rearb when idle", gnt, 3'b100);
    sack = 3'b010;
    cyc();
    sack = 3'b000;
    chk(sel == 0, "R6 release after stall", sel, 0);

    // R5: lock keeps ownership
    own(0);
    req = 3'b111; lock = 1'b1; addr = mk(0); vld = 1'b1;
    cyc();
    chk(gnt == 3'b001 && sel == 3'b001, "R5 locked accept", {gnt, sel}, {3'b001, 3'b001});
    vld = 1'b0; lock = 1'b0; sack = 3'b010;
    cyc();
    sack = 3'b000;
    chk(gnt == 3'b001 && sel == 0, "R5 lock held idle", {gnt, sel}, {3'b001, 3'b000});
    cyc();
    chk(gnt == 3'b001, "R5 lock held later", gnt, 3'b001);
    addr = mk(1); vld = 1'b1;
    cyc();
    chk(gnt == 3'b010 && sel == 3'b010, "R5 unlock rearb", {gnt, sel}, {3'b010, 3'b010});
    vld = 1'b0; sack = 3'b010;
    cyc();
    sack = 3'b000;

    // R10: timeout, lock released
    own(0);
    req = 3'b111; lock = 1'b1; addr = mk(2); vld = 1'b1;
    cyc();
    chk(gnt == 3'b001, "R10 locked owner", gnt, 3'b001);
    vld = 1'b0; lock = 1'b0; sack = 3'b001;
    cyc();
    chk(sel == 3'b100, "R11 wait 2", sel, 3'b100);
    cyc();
    cyc();
    chk(sel == 3'b100 && tout == 0, "R11 wait 4", {sel, tout}, {3'b100, 1'b0});
    cyc();
    chk(sel == 0 && ack == 3'b101 && tout == 1 && gnt == 3'b001, "R10 timeout",
        {gnt, sel, ack, tout}, {3'b001, 3'b000, 3'b101, 1'b1});
    cyc();
    chk(ack == 0 && tout == 0 && gnt == 3'b010, "R10 after timeout",
        {gnt, ack, tout}, {3'b010, 3'b000, 1'b0});
    sack = 3'b000;

    // R11: ready in last allowed cycle
    req = 3'b000; addr = mk(1); vld = 1'b1;
    cyc();
    vld = 1'b0; sack = 3'b001;
    cyc();
    cyc();
    cyc();
    chk(sel == 3'b010, "R11 still selected", sel, 3'b010);
    sack = 3'b010;
    cyc();
    sack = 3'b000;
    chk(sel == 0 && ack == 0 && tout == 0, "R11 no timeout", {sel, ack, tout}, 0);

    // R7: overlap and stall
    addr = mk(0); vld = 1'b1;
    cyc();
    addr = mk(2); sack = 3'b001;
    cyc();
    chk(sel == 3'b001, "R7 stalled address", sel, 3'b001);
    sack = 3'b010;
    cyc();
    chk(sel == 3'b100 && ack == 0, "R7 overlap accept", {sel, ack}, {3'b100, 3'b000});
    vld = 1'b0;
    cyc();
    sack = 3'b000;
    chk(sel == 0, "R7 drain", sel, 0);
    addr = mk(3); vld = 1'b1;
    cyc();
    chk(ack == 3'b100, "R8 error before overlap", ack, 3'b100);
    addr = mk(1);
    cyc();
    vld = 1'b0;
    chk(sel == 3'b010 && ack == 0, "R7 accept during error", {sel, ack}, {3'b010, 3'b000});
    sack = 3'b010;
    cyc();
    sack = 3'b000;
    chk(sel == 0, "R7 final release", sel, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule